// File: doc/BRIEF.md
# Decade Event Counter with Decoded Terminal Clear

This block counts event strobes in binary-coded decimal, from 0 up to 9 and back to 0. It is written as a synchronous model of a chain of toggle cells. Bit 0 flips on every accepted event. Each higher bit flips when every bit below it is about to roll over, so each stage changes half as often as the stage below it.

The wrap back to 0 does not come from a compare against nine. A two-bit detector watches the candidate next value. When that value would have bit 3 and bit 1 both high (first reached at 1010), an active-low terminal signal clears all four stages in the same cycle, so 1010 never reaches the output. The same edge raises a one-cycle carry that a following stage or timer can consume.

An active-low synchronous clear returns the count to zero at any edge and beats an event. The block also has an asynchronous active-low reset, which is released through a two-flop synchronizer.

Top module: `decade_counter`

## Requirements
- R1: While `rst_n` is low, `bcd_o` reads 0 and `carry_o` reads 0; after release the count stays 0 until the first accepted event.
- R2: With `clr_ni` high and the count at 0 to 8, a cycle with `evt_i` high makes `bcd_o` equal to the old count plus one (plain binary, bit 0 the least significant) after that clock edge.
- R3: With `clr_ni` high and the count at 9 (binary 1001), a cycle with `evt_i` high makes `bcd_o` 0 after the edge; `bcd_o` never shows a value above 9.
- R4: With `clr_ni` high and `evt_i` low, `bcd_o` keeps its value across the edge and `carry_o` is 0.
- R5: A cycle with `clr_ni` low sets `bcd_o` to 0 and `carry_o` to 0 after the edge, whatever `evt_i` and the count are.
- R6: `carry_o` is high for exactly the one cycle that follows an edge at which the count moved from 9 to 0 because of an event, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_i | input | 1 | Event strobe, one count per cycle it is high |
| clr_ni | input | 1 | Synchronous active-low clear, priority over events |
| bcd_o | output | 4 | Current decade count, 0 to 9 |
| carry_o | output | 1 | One-cycle pulse on the 9 to 0 wrap |

## Verification
The properties assume that `evt_i` and `clr_ni` are driven to known levels and change only between clock edges. They also assume that reset is held long enough for the synchronizer to settle, and no property is evaluated while the synchronized reset is active. The bench changes inputs only on falling edges and stays idle during the synchronizer latency after reset release. It then mixes single strobes, long strobe runs across several wraps, idle gaps, and clears placed at 9, mid-count and on top of an event.

// File: rtl/dec_pkg.sv
package dec_pkg;
  // Width of one decade stage chain and the highest legal code.
  localparam int unsigned DEC_W     = 4;
  localparam int unsigned DEC_LAST  = 9;
  // Bits whose joint set state marks the first code past the last one.
  localparam int unsigned TERM_HI   = 3;
  localparam int unsigned TERM_LO   = 1;

  typedef logic [DEC_W-1:0] bcd_t;
endpackage

// File: rtl/dec_reset_sync.sv
module dec_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/dec_toggle_stage.sv
module dec_toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_i,
  input  logic clr_i,
  output logic q_o,
  output logic d_raw_o
);
  logic q_d;

  // Toggle cell: both control inputs tied active, so the enable alone flips it.
  assign d_raw_o = q_o ^ tgl_i;

  always_comb begin
    if (clr_i) q_d = 1'b0;
    else       q_d = d_raw_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/dec_term_detect.sv
module dec_term_detect
  import dec_pkg::*;
(
  input  bcd_t nxt_i,
  input  bcd_t cur_i,
  output logic term_n_o,
  output logic bad_cur_o
);
  // Active-low terminal detect: only the two marker bits are looked at.
  assign term_n_o  = ~(nxt_i[TERM_HI] & nxt_i[TERM_LO]);
  // Recovery decode for codes 10..15 held in the register.
  assign bad_cur_o = cur_i[DEC_W-1] & (cur_i[DEC_W-2] | cur_i[TERM_LO]);
endmodule

// File: rtl/dec_carry_gen.sv
module dec_carry_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_ni,
  input  logic term_n_i,
  input  logic bad_cur_i,
  output logic carry_o
);
  logic carry_d;

  always_comb begin
    carry_d = evt_i & clr_ni & ~term_n_i & ~bad_cur_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_o <= 1'b0;
    else        carry_o <= carry_d;
  end
endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import dec_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_i,
  input  logic       clr_ni,
  output logic [3:0] bcd_o,
  output logic       carry_o
);
  logic             rst_q;
  bcd_t             q;
  bcd_t             d_raw;
  logic [DEC_W-1:0] tgl;
  logic             term_n;
  logic             bad_cur;
  logic             clr_all;

  dec_reset_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  // Toggle enables: stage i flips when the event reaches it through all-ones below.
  assign tgl[0] = evt_i;
  for (genvar i = 1; i < DEC_W; i++) begin : g_tgl
    assign tgl[i] = tgl[i-1] & q[i-1];
  end

  dec_term_detect u_term (
    .nxt_i     (d_raw),
    .cur_i     (q),
    .term_n_o  (term_n),
    .bad_cur_o (bad_cur)
  );

  always_comb begin
    clr_all = ~clr_ni | (evt_i & (~term_n | bad_cur));
  end

  for (genvar i = 0; i < DEC_W; i++) begin : g_stage
    dec_toggle_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_q),
      .tgl_i   (tgl[i]),
      .clr_i   (clr_all),
      .q_o     (q[i]),
      .d_raw_o (d_raw[i])
    );
  end

  dec_carry_gen u_carry (
    .clk       (clk),
    .rst_n     (rst_q),
    .evt_i     (evt_i),
    .clr_ni    (clr_ni),
    .term_n_i  (term_n),
    .bad_cur_i (bad_cur),
    .carry_o   (carry_o)
  );

  assign bcd_o = q;
endmodule

// File: rtl/dec_counter_chk.sv
module dec_counter_chk (
  input logic       clk,
  input logic       rst_q,
  input logic       evt,
  input logic       clr_n,
  input logic [3:0] cnt,
  input logic       carry
);
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_q |-> (cnt == 4'd0 && !carry));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (evt && clr_n && cnt < 4'd9) |=> (cnt == 4'($past(cnt) + 4'd1)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (evt && clr_n && cnt == 4'd9) |=> (cnt == 4'd0));

  p_legal_r3: assert property (@(posedge clk) disable iff (!rst_q)
    cnt <= 4'd9);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (!evt && clr_n) |=> ($stable(cnt) && !carry));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !clr_n |=> (cnt == 4'd0 && !carry));

  p_carry_set_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (evt && clr_n && cnt == 4'd9) |=> carry);

  p_carry_once_r6: assert property (@(posedge clk) disable iff (!rst_q)
    carry |=> !carry);
endmodule

bind decade_counter dec_counter_chk u_chk (
  .clk   (clk),
  .rst_q (rst_q),
  .evt   (evt_i),
  .clr_n (clr_ni),
  .cnt   (bcd_o),
  .carry (carry_o)
);

// File: tb/decade_counter_test.sv
module decade_counter_test;
  typedef struct {
    logic [3:0] cnt;
    logic       cy;
    string      req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       evt_i;
  logic       clr_ni;
  logic [3:0] bcd_o;
  logic       carry_o;

  int   n_chk;
  int   n_bad;
  logic [3:0] model;
  exp_t q[$];
  bit   done;

  decade_counter uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .clr_ni  (clr_ni),
    .bcd_o   (bcd_o),
    .carry_o (carry_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [3:0] ac, input logic ay,
                       input logic [3:0] ec, input logic ey);
    n_chk++;
    if (ac !== ec || ay !== ey) begin
      n_bad++;
      $display("FAIL %s: count=%0d carry=%0b expected count=%0d carry=%0b",
               req, ac, ay, ec, ey);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic e, input logic c, input string req);
    exp_t it;
    @(negedge clk);
    evt_i  = e;
    clr_ni = c;
    it.cy  = c && e && (model == 4'd9);
    if (!c)          model = 4'd0;
    else if (e)      model = (model == 4'd9) ? 4'd0 : model + 4'd1;
    it.cnt = model;
    it.req = req;
    q.push_back(it);
  endtask

  // Monitor: compares just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check(it.req, bcd_o, carry_o, it.cnt, it.cy);
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: count=%0d carry=%0b expected finish", bcd_o, carry_o);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0; model = 4'd0;
    evt_i = 1'b0; clr_ni = 1'b1; rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", bcd_o, carry_o, 4'd0, 1'b0);   // R1 during reset
    evt_i = 1'b1;
    @(negedge clk);
    check("R1", bcd_o, carry_o, 4'd0, 1'b0);   // R1 event ignored in reset
    evt_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", bcd_o, carry_o, 4'd0, 1'b0);   // R1 after release

    // R2 single strobes with gaps (R4 holds between them)
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b1, "R2");
      step(1'b0, 1'b1, "R4");
    end
    // R2 then R3 and R6 on a continuous run across three wraps
    for (int i = 0; i < 28; i++) step(1'b1, 1'b1, "R3/R6");
    for (int i = 0; i < 3; i++)  step(1'b0, 1'b1, "R4");
    // R5 clear mid-count, clear with event, clear at 9
    step(1'b0, 1'b0, "R5");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R2");
    step(1'b1, 1'b0, "R5");
    for (int i = 0; i < 9; i++) step(1'b1, 1'b1, "R2");
    step(1'b1, 1'b0, "R5");       // R5 at 9: no carry
    step(1'b0, 1'b1, "R4");
    // R6 isolated wrap then idle
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, "R6");
    for (int i = 0; i < 2; i++)  step(1'b0, 1'b1, "R4");
    // R3 alternating strobe pattern across a wrap
    for (int i = 0; i < 24; i++) step(i[0] ? 1'b0 : 1'b1, 1'b1, "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule